// File: doc/BRIEF.md
# Vector Group Broadcast-Add Unit

This block performs one vector operation. It adds a single source vector to every register of a group of two or four consecutive destination registers. Each sum overwrites the register it came from. The unit holds its own 32-entry vector register file, whose width `VLEN` is a compile-time multiple of 64 bits. Its adder is partitioned, and each operation chooses a lane width of 8, 16, 32 or 64 bits.

An operation begins when the unit is idle and `start` is high for one cycle. On that cycle the unit samples:
- the group-size select,
- the encoded group field,
- the source field,
- the size code,
- the feature-enable input.

The unit then works through the group one register per clock and stores each sum in a shadow buffer. After all sums exist, it writes them back one register per clock. Because of this order, a source register that lies inside the group still supplies its original value to every sum. A separate test port lets a testbench preload the register file and read it back while the unit is idle.

Top module: `vbadd_unit`

## Requirements
- R1: `size_code` selects the lane width as 8 << size_code: 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit. Each lane sum wraps modulo 2^width, and no carry passes into the next lane.
- R2: When `quad`=0, the group is the registers numbered 2·g and 2·g+1, where g is the 4-bit `grp_fld`.
- R3: When `quad`=1, the group is the registers numbered 4·g through 4·g+3, where g is `grp_fld[2:0]`. Bit 3 of `grp_fld` is ignored.
- R4: The source register number is `src_fld` (0 to 15). The same unchanged source vector is added, lane by lane, to every register of the group.
- R5: Every sum is formed from register contents as they were before the operation, even when the source register is inside the group.
- R6: An operation leaves every register outside its group unchanged.
- R7: When `feat_en`=0 at start, `undef` is high for exactly the next cycle, `done` stays low and no register changes.
- R8: `done` is a one-cycle pulse that follows the last write-back. With N group registers, `done` is first seen high 2·N clock edges after the edge that accepted `start`. `done` and `undef` are low after reset.
- R9: While idle, `dbg_we` writes `dbg_wdata` into register `dbg_waddr`, and `dbg_rdata` shows register `dbg_raddr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; only accepted while idle |
| feat_en | input | 1 | Multi-register operations enabled |
| quad | input | 1 | 1 = four-register group, 0 = two-register group |
| grp_fld | input | 4 | Encoded group index |
| src_fld | input | 4 | Source register number 0 to 15 |
| size_code | input | 2 | Lane width select |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle undefined-operation flag |
| dbg_we | input | 1 | Test-port write enable |
| dbg_waddr | input | 5 | Test-port write register |
| dbg_wdata | input | VLEN | Test-port write data |
| dbg_raddr | input | 5 | Test-port read register |
| dbg_rdata | output | VLEN | Test-port read data |

## Verification
The tests use these input patterns, each aimed at a different fault:
- **All-ones source in 8-bit lanes.** Every lane must wrap, so a carry leaking between lanes shows up in the result.
- **64-bit lanes on low words set to all ones.** A partition boundary wrongly placed at 32 bits would be caught.
- **Several sizes, group forms and group fields, including a field with bit 3 set in the four-register form.** These separate the two base scalings from each other.
- **A source register placed inside its own group.** Only snapshot-before-write ordering gives the expected values here.

After each operation, a full scan of the register file shows any write that strayed outside the group. A disabled operation must leave that scan identical.

// File: rtl/vbadd_pkg.sv
package vbadd_pkg;

    localparam int unsigned NREGS  = 32;
    localparam int unsigned RIDX_W = $clog2(NREGS);
    localparam int unsigned MAXGRP = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_WB
    } vb_state_e;

    typedef struct packed {
        logic [RIDX_W-1:0] base;
        logic [3:0]        src;
        logic [1:0]        sz;
        logic              quad;
    } vb_op_t;

    // scaled group base: field x2 for pairs, field x4 for quads
    function automatic logic [RIDX_W-1:0] group_base(input logic [3:0] fld,
                                                     input logic       quad);
        return quad ? {fld[2:0], 2'b00} : {fld, 1'b0};
    endfunction

    function automatic logic [1:0] last_step(input logic quad);
        return quad ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/vbadd_regfile.sv
module vbadd_regfile
    import vbadd_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [VLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] ra_a,
    output logic [VLEN-1:0]   rd_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [VLEN-1:0]   rd_b,
    input  logic [RIDX_W-1:0] ra_c,
    output logic [VLEN-1:0]   rd_c
);

    logic [VLEN-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rd_a = mem[ra_a];
    assign rd_b = mem[ra_b];
    assign rd_c = mem[ra_c];

endmodule

// File: rtl/vbadd_lane_adder.sv
module vbadd_lane_adder #(
    parameter int unsigned VLEN = 128
) (
    input  logic [VLEN-1:0] a,
    input  logic [VLEN-1:0] b,
    input  logic [1:0]      sz,
    output logic [VLEN-1:0] sum
);

    localparam int unsigned NSLICE = VLEN / 64;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        logic [63:0] cand [4];
        for (genvar w = 0; w < 4; w++) begin : g_width
            localparam int unsigned LW = 8 << w;
            localparam int unsigned NL = 64 / LW;
            for (genvar l = 0; l < NL; l++) begin : g_lane
                assign cand[w][l*LW +: LW] = a[s*64 + l*LW +: LW] + b[s*64 + l*LW +: LW];
            end
        end
        assign sum[s*64 +: 64] = cand[sz];
    end

endmodule

// File: rtl/vbadd_ctrl.sv
module vbadd_ctrl
    import vbadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              feat_en,
    input  logic              quad,
    input  logic [3:0]        grp_fld,
    input  logic [3:0]        src_fld,
    input  logic [1:0]        size_code,
    output vb_op_t            op,
    output logic [1:0]        step,
    output logic              cap_en,
    output logic              wr_en,
    output logic              busy,
    output logic              done,
    output logic              undef
);

    vb_state_e state_q;
    logic [1:0] step_q;
    vb_op_t     op_q;
    logic       done_q, undef_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            op_q    <= '0;
            done_q  <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            undef_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (!feat_en) begin
                            undef_q <= 1'b1;
                        end else begin
                            op_q.base <= group_base(grp_fld, quad);
                            op_q.src  <= src_fld;
                            op_q.sz   <= size_code;
                            op_q.quad <= quad;
                            step_q    <= '0;
                            state_q   <= ST_CALC;
                        end
                    end
                end
                ST_CALC: begin
                    if (step_q == last_step(op_q.quad)) begin
                        step_q  <= '0;
                        state_q <= ST_WB;
                    end else begin
                        step_q <= step_q + 2'd1;
                    end
                end
                ST_WB: begin
                    if (step_q == last_step(op_q.quad)) begin
                        step_q  <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + 2'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op     = op_q;
    assign step   = step_q;
    assign cap_en = (state_q == ST_CALC);
    assign wr_en  = (state_q == ST_WB);
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign undef  = undef_q;

endmodule

// File: rtl/vbadd_unit.sv
module vbadd_unit
    import vbadd_pkg::*;
#(
    parameter int unsigned VLEN = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              feat_en,
    input  logic              quad,
    input  logic [3:0]        grp_fld,
    input  logic [3:0]        src_fld,
    input  logic [1:0]        size_code,
    output logic              done,
    output logic              undef,
    input  logic              dbg_we,
    input  logic [4:0]        dbg_waddr,
    input  logic [VLEN-1:0]   dbg_wdata,
    input  logic [4:0]        dbg_raddr,
    output logic [VLEN-1:0]   dbg_rdata
);

    vb_op_t            op;
    logic [1:0]        step;
    logic              cap_en, wr_en, busy;
    logic [RIDX_W-1:0] grp_reg;
    logic [VLEN-1:0]   opa, opb, lane_sum;
    logic [VLEN-1:0]   shadow_q [MAXGRP];
    logic              eng_we;
    logic [RIDX_W-1:0] eng_waddr;
    logic [VLEN-1:0]   eng_wdata;

    vbadd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .feat_en(feat_en), .quad(quad),
        .grp_fld(grp_fld), .src_fld(src_fld), .size_code(size_code),
        .op(op), .step(step), .cap_en(cap_en), .wr_en(wr_en), .busy(busy),
        .done(done), .undef(undef)
    );

    assign grp_reg = op.base + RIDX_W'(step);

    assign eng_we    = wr_en | (dbg_we & ~busy);
    assign eng_waddr = wr_en ? grp_reg : dbg_waddr;
    assign eng_wdata = wr_en ? shadow_q[step] : dbg_wdata;

    vbadd_regfile #(.VLEN(VLEN)) u_rf (
        .clk(clk), .we(eng_we), .waddr(eng_waddr), .wdata(eng_wdata),
        .ra_a(grp_reg), .rd_a(opa),
        .ra_b({1'b0, op.src}), .rd_b(opb),
        .ra_c(dbg_raddr), .rd_c(dbg_rdata)
    );

    vbadd_lane_adder #(.VLEN(VLEN)) u_add (
        .a(opa), .b(opb), .sz(op.sz), .sum(lane_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAXGRP; i++) shadow_q[i] <= '0;
        end else if (cap_en) begin
            shadow_q[step] <= lane_sum;
        end
    end

endmodule

// File: rtl/vbadd_checker.sv
module vbadd_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       feat_en,
    input logic       busy,
    input logic       done,
    input logic       undef,
    input logic       eng_we,
    input logic [4:0] eng_waddr,
    input logic [4:0] base,
    input logic       quad,
    input logic       wr_en
);

    AST_UNDEF_ON_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !feat_en) |=> undef); // R7
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        undef |-> (!done && !busy && !wr_en)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en)); // R8
    AST_WRITE_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (eng_we && eng_waddr >= base
                   && eng_waddr <= base + (quad ? 5'd3 : 5'd1))); // R6
    AST_NO_WB_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en); // R6

endmodule

bind vbadd_unit vbadd_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .feat_en(feat_en), .busy(busy),
    .done(done), .undef(undef), .eng_we(eng_we), .eng_waddr(eng_waddr),
    .base(op.base), .quad(op.quad), .wr_en(wr_en)
);

// File: tb/tb_vbadd_unit.sv
module tb_vbadd_unit;

    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 128;

    typedef struct packed {
        logic [4:0]      addr;
        logic [VLEN-1:0] val;
        logic [31:0]     tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, feat_en = 1'b1, quad = 1'b0;
    logic [3:0] grp_fld = '0, src_fld = '0;
    logic [1:0] size_code = '0;
    logic done, undef;
    logic dbg_we = 1'b0;
    logic [4:0] dbg_waddr = '0, dbg_raddr = '0;
    logic [VLEN-1:0] dbg_wdata = '0, dbg_rdata;

    int total = 0, fails = 0;
    logic [VLEN-1:0] model [32];
    exp_t q[$];
    logic scan_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbadd_unit #(.VLEN(VLEN)) dut (
        .clk(clk), .rst(rst), .start(start), .feat_en(feat_en), .quad(quad),
        .grp_fld(grp_fld), .src_fld(src_fld), .size_code(size_code),
        .done(done), .undef(undef), .dbg_we(dbg_we), .dbg_waddr(dbg_waddr),
        .dbg_wdata(dbg_wdata), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    task automatic check(input logic [31:0] tag, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [VLEN-1:0] ref_add(input logic [VLEN-1:0] a,
                                                input logic [VLEN-1:0] b,
                                                input int es);
        logic [VLEN-1:0] r = '0;
        logic [63:0] m = (es == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << es) - 64'd1);
        for (int e = 0; e < VLEN / es; e++) begin
            logic [63:0] x, y, s;
            x = 64'(a >> (e * es)) & m;
            y = 64'(b >> (e * es)) & m;
            s = (x + y) & m;
            r = r | (VLEN'(s) << (e * es));
        end
        return r;
    endfunction

    // monitor: pops expected items and compares them via the test read port
    initial begin
        forever begin
            wait (scan_req);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                dbg_raddr = it.addr;
                #1;
                check(it.tag, dbg_rdata, it.val);
            end
            scan_req = 1'b0;
        end
    end

    task automatic push_scan(input logic [4:0] lo, input logic [4:0] hi,
                             input logic [31:0] gtag);
        for (int i = 0; i < 32; i++) begin
            exp_t it;
            it.addr = 5'(i);
            it.val  = model[i];
            it.tag  = (i >= lo && i <= hi) ? gtag : "R6";
            q.push_back(it);
        end
        @(negedge clk);
        scan_req = 1'b1;
        wait (!scan_req);
    endtask

    task automatic preload(input int a, input logic [VLEN-1:0] v);
        @(negedge clk);
        dbg_we = 1'b1; dbg_waddr = 5'(a); dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
        model[a] = v;
    endtask

    task automatic run_op(input logic qd, input logic [3:0] fld, input logic [3:0] src,
                          input logic [1:0] sz, input logic fe, input logic [31:0] tag);
        int n = qd ? 4 : 2;
        int base = qd ? int'(fld[2:0]) * 4 : int'(fld) * 2;
        logic [VLEN-1:0] res [4];
        int cnt = 0;
        if (fe) begin
            for (int r = 0; r < n; r++) res[r] = ref_add(model[base + r], model[src], 8 << sz);
            for (int r = 0; r < n; r++) model[base + r] = res[r];
        end
        @(negedge clk);
        start = 1'b1; feat_en = fe; quad = qd; grp_fld = fld; src_fld = src; size_code = sz;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (fe) begin
            while (!done && cnt < 20) begin
                @(negedge clk);
                cnt++;
            end
            check("R8", VLEN'(cnt), VLEN'(2 * n));
            @(negedge clk);
            check("R8", VLEN'(done), '0);
        end else begin
            check("R7", VLEN'({undef, done}), VLEN'(2'b10));
            @(negedge clk);
            check("R7", VLEN'({undef, done}), '0);
            repeat (10) begin
                @(negedge clk);
                if (done) check("R7", VLEN'(done), '0);
            end
        end
        push_scan(5'(base), fe ? 5'(base + n - 1) : 5'd0, fe ? tag : "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8", VLEN'({done, undef}), '0);

        // R9: preload through the test port, then read all back
        for (int i = 0; i < 32; i++) begin
            logic [VLEN-1:0] v;
            for (int k = 0; k < VLEN / 32; k++)
                v[k*32 +: 32] = (32'(i) * 32'h9E37_79B9) ^ (32'(k) * 32'h7F4A_7C15) ^ 32'h5A5A_00C3;
            preload(i, v);
        end
        preload(10, '1);
        preload(13, {(VLEN/64){64'h0000_0000_FFFF_FFFF}});
        preload(12, {(VLEN/64){64'h0000_0000_0000_0001}});
        push_scan(5'd0, 5'd31, "R9");

        run_op(1'b0, 4'd3,  4'd10, 2'd0, 1'b1, "R1");  // regs 6,7 + all-ones, 8-bit wrap
        run_op(1'b1, 4'd13, 4'd2,  2'd1, 1'b1, "R3");  // field bit3 ignored -> regs 20..23
        run_op(1'b0, 4'd15, 4'd0,  2'd2, 1'b1, "R2");  // regs 30,31
        run_op(1'b0, 4'd7,  4'd15, 2'd2, 1'b1, "R5");  // source reg 15 inside group 14,15
        run_op(1'b1, 4'd3,  4'd13, 2'd3, 1'b1, "R5");  // 64-bit lanes, source 13 inside 12..15
        run_op(1'b1, 4'd6,  4'd9,  2'd2, 1'b1, "R4");  // regs 24..27 share source 9
        run_op(1'b1, 4'd0,  4'd1,  2'd0, 1'b1, "R1");  // regs 0..3, source 1 inside
        run_op(1'b0, 4'd5,  4'd3,  2'd1, 1'b0, "R7");  // disabled: nothing changes

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule